// File: doc/BRIEF.md
# SPI Host Interrupt Aggregator

This block turns the error and event conditions of an SPI host controller into two level interrupt outputs. One output is for errors and one is for events. Other parts of the controller send in one-cycle error pulses and three steady status flags: ready for a command, transmit queue empty and receive queue full. A small word-addressed register port lets software set the enables, clear pending interrupts, force an interrupt for test and read or clear the latched error record.

An interrupt line is considered only while its enable bit is set and its pending (state) bit is clear. If any of its individually enabled sources is active, or software writes the matching test bit, the state bit sets on the next clock edge. The bit then stays set until software writes a 1 to it. Each output is the state bit gated by the enable bit. The asynchronous active-low reset is released to the logic through a short synchronizer.

Top module: `spi_irq_hub`

## Requirements
- R1: In the pending-state, enable and test registers, bit 0 belongs to the error interrupt and bit 1 to the event interrupt. A set state bit stays set until software writes 1 to that bit of the state register (word address 0). Writing 0 leaves it unchanged.
- R2: A state bit can become set only while its enable bit is 1 and the state bit itself is 0. The bit sets on the clock edge that samples an active cause. With the enable bit at 0, neither a source nor a test write sets it.
- R3: Writing 1 to a bit of the test register (word address 2) sets the matching state bit on that write's edge, whatever the sources are. The test register always reads as zero.
- R4: The error interrupt has three causes: command-busy (error-enable bit 0), invalid command (bit 3) and invalid chip select (bit 4). Each counts only while both its error-enable bit and its error-status bit are 1.
- R5: The event interrupt has three causes: ready (event-enable bit 4), TX empty (bit 1) and RX full (bit 0). Each counts only while both its event-enable bit and its input flag are 1. Event-enable bits 2, 3 and 5 are stored but raise nothing.
- R6: After reset the error-enable register (word address 4) reads 0x1F. Every other register reads zero, and both interrupt outputs are 0.
- R7: Error-status bits (word address 5) set on their input pulse and stay set until software writes 1 to them.
- R8: Error-status bit layout: 0 command-busy, 1 overflow, 2 underflow, 3 invalid command, 4 invalid chip select, 5 access-invalid. Overflow, underflow and access-invalid are recorded but never raise the error interrupt.
- R9: Each interrupt output equals its state bit ANDed with its enable bit. Clearing the enable bit masks the output but keeps the state bit.
- R10: If an error pulse and a software clear reach the same status bit in the same cycle, the bit stays set. Bits cleared in that write that have no pulse do clear.
- R11: A write to the alert-test word (address 3) changes no register and no output.
- R12: Word map: 0 state, 1 enable, 2 test, 3 alert test, 4 error enable, 5 error status, 6 event enable. Unused bits and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| st_ready | input | 1 | Controller ready for a command |
| st_tx_empty | input | 1 | Transmit queue empty |
| st_rx_full | input | 1 | Receive queue full |
| ep_cmd_busy | input | 1 | Pulse: command issued while busy |
| ep_overflow | input | 1 | Pulse: transmit queue overflow |
| ep_underflow | input | 1 | Pulse: receive queue underflow |
| ep_cmd_inval | input | 1 | Pulse: invalid command |
| ep_cs_inval | input | 1 | Pulse: invalid chip-select index |
| ep_access_inval | input | 1 | Pulse: invalid register access |
| irq_err | output | 1 | Error interrupt level |
| irq_evt | output | 1 | Event interrupt level |

## Verification
The two functions that can land in the same cycle are an error pulse from the controller and a software write that clears the error-status register. The bench drives a command-busy pulse on the same clock as a write that clears both bit 0 and bit 3, with bit 3 already set. It then expects the read back to show bit 0 still set and bit 3 gone. A following plain clear must then empty the register, which shows that the surviving bit came from the new pulse.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  // interrupt line indices (also bit positions in state/enable/test)
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_ERR  = 0;
  localparam int unsigned LINE_EVT  = 1;

  // field widths
  localparam int unsigned ERR_W   = 6;
  localparam int unsigned ERREN_W = 5;
  localparam int unsigned EVTEN_W = 6;

  // error status / enable bit positions
  localparam int unsigned EB_CMD_BUSY  = 0;
  localparam int unsigned EB_OVERFLOW  = 1;
  localparam int unsigned EB_UNDERFLOW = 2;
  localparam int unsigned EB_CMD_INVAL = 3;
  localparam int unsigned EB_CS_INVAL  = 4;
  localparam int unsigned EB_ACCESS    = 5;

  // event enable bit positions
  localparam int unsigned VB_RX_FULL  = 0;
  localparam int unsigned VB_TX_EMPTY = 1;
  localparam int unsigned VB_READY    = 4;

  localparam logic [ERREN_W-1:0] ERREN_RST = 5'h1F;

  // word addresses
  localparam int unsigned AD_STATE  = 0;
  localparam int unsigned AD_ENABLE = 1;
  localparam int unsigned AD_TEST   = 2;
  localparam int unsigned AD_ALERT  = 3;
  localparam int unsigned AD_ERR_EN = 4;
  localparam int unsigned AD_ERR_ST = 5;
  localparam int unsigned AD_EVT_EN = 6;
endpackage

// File: rtl/spi_irq_csr.sv
module spi_irq_csr
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] state_q,
  input  logic [ERR_W-1:0]     err_st_q,
  output logic [NUM_LINES-1:0] int_en_q,
  output logic [ERREN_W-1:0]   err_en_q,
  output logic [EVTEN_W-1:0]   evt_en_q,
  output logic [NUM_LINES-1:0] test_pulse,
  output logic [NUM_LINES-1:0] state_clr,
  output logic [ERR_W-1:0]     errst_clr,
  output logic [DATA_W-1:0]    rdata
);
  logic [31:0] addr_ext;
  logic        sel_state, sel_en, sel_test, sel_erren, sel_errst, sel_evten;
  logic [NUM_LINES-1:0] int_en_d;
  logic [ERREN_W-1:0]   err_en_d;
  logic [EVTEN_W-1:0]   evt_en_d;
  logic                 unused_wdata;

  assign addr_ext  = 32'(addr);
  assign sel_state = we && (addr_ext == AD_STATE);
  assign sel_en    = we && (addr_ext == AD_ENABLE);
  assign sel_test  = we && (addr_ext == AD_TEST);
  assign sel_erren = we && (addr_ext == AD_ERR_EN);
  assign sel_errst = we && (addr_ext == AD_ERR_ST);
  assign sel_evten = we && (addr_ext == AD_EVT_EN);
  // alert-test address decodes to nothing: accepted, no effect

  assign test_pulse   = sel_test  ? wdata[NUM_LINES-1:0] : '0;
  assign state_clr    = sel_state ? wdata[NUM_LINES-1:0] : '0;
  assign errst_clr    = sel_errst ? wdata[ERR_W-1:0]     : '0;
  assign unused_wdata = ^wdata[DATA_W-1:EVTEN_W];

  always_comb begin
    int_en_d = sel_en    ? wdata[NUM_LINES-1:0] : int_en_q;
    err_en_d = sel_erren ? wdata[ERREN_W-1:0]   : err_en_q;
    evt_en_d = sel_evten ? wdata[EVTEN_W-1:0]   : evt_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q <= '0;
      err_en_q <= ERREN_RST;
      evt_en_q <= '0;
    end else begin
      if (sel_en)    int_en_q <= int_en_d;
      if (sel_erren) err_en_q <= err_en_d;
      if (sel_evten) evt_en_q <= evt_en_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr_ext)
      AD_STATE:  rdata[NUM_LINES-1:0] = state_q;
      AD_ENABLE: rdata[NUM_LINES-1:0] = int_en_q;
      AD_ERR_EN: rdata[ERREN_W-1:0]   = err_en_q;
      AD_ERR_ST: rdata[ERR_W-1:0]     = err_st_q;
      AD_EVT_EN: rdata[EVTEN_W-1:0]   = evt_en_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_errlog.sv
module spi_irq_errlog
  import spi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] pulses,
  input  logic [ERR_W-1:0] clr,
  output logic [ERR_W-1:0] st_q
);
  logic [ERR_W-1:0] st_d;
  logic             upd;

  // a fresh pulse outranks a same-cycle software clear
  always_comb begin
    st_d = (st_q & ~clr) | pulses;
    upd  = |(pulses | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '0;
    else if (upd) st_q <= st_d;
  end
endmodule

// File: rtl/spi_irq_line.sv
module spi_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic test,
  input  logic clr,
  input  logic cause,
  output logic state_q,
  output logic irq
);
  logic arm, fire, state_d, upd;

  always_comb begin
    arm     = en & ~state_q;
    fire    = arm & (test | cause);
    state_d = fire | (state_q & ~clr);
    upd     = fire | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= 1'b0;
    else if (upd) state_q <= state_d;
  end

  assign irq = state_q & en;
endmodule

// File: rtl/spi_irq_hub.sv
module spi_irq_hub
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              st_ready,
  input  logic              st_tx_empty,
  input  logic              st_rx_full,
  input  logic              ep_cmd_busy,
  input  logic              ep_overflow,
  input  logic              ep_underflow,
  input  logic              ep_cmd_inval,
  input  logic              ep_cs_inval,
  input  logic              ep_access_inval,
  output logic              irq_err,
  output logic              irq_evt
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic [NUM_LINES-1:0] int_state_q, int_en_q, test_pulse, state_clr, cause, irq_vec;
  logic [ERREN_W-1:0]   err_en_q;
  logic [EVTEN_W-1:0]   evt_en_q;
  logic [ERR_W-1:0]     err_st_q, err_pulses, errst_clr;

  assign err_pulses = {ep_access_inval, ep_cs_inval, ep_cmd_inval,
                       ep_underflow, ep_overflow, ep_cmd_busy};

  spi_irq_csr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .state_q(int_state_q), .err_st_q(err_st_q), .int_en_q(int_en_q),
    .err_en_q(err_en_q), .evt_en_q(evt_en_q), .test_pulse(test_pulse),
    .state_clr(state_clr), .errst_clr(errst_clr), .rdata(reg_rdata)
  );

  spi_irq_errlog u_errlog (
    .clk(clk), .rst_n(rst_sync_n), .pulses(err_pulses), .clr(errst_clr), .st_q(err_st_q)
  );

  always_comb begin
    cause[LINE_ERR] = (err_en_q[EB_CMD_BUSY]  & err_st_q[EB_CMD_BUSY])
                    | (err_en_q[EB_CMD_INVAL] & err_st_q[EB_CMD_INVAL])
                    | (err_en_q[EB_CS_INVAL]  & err_st_q[EB_CS_INVAL]);
    cause[LINE_EVT] = (evt_en_q[VB_READY]    & st_ready)
                    | (evt_en_q[VB_TX_EMPTY] & st_tx_empty)
                    | (evt_en_q[VB_RX_FULL]  & st_rx_full);
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    spi_irq_line u_line (
      .clk(clk), .rst_n(rst_sync_n), .en(int_en_q[g]), .test(test_pulse[g]),
      .clr(state_clr[g]), .cause(cause[g]), .state_q(int_state_q[g]), .irq(irq_vec[g])
    );
  end

  assign irq_err = irq_vec[LINE_ERR];
  assign irq_evt = irq_vec[LINE_EVT];
endmodule

// File: rtl/spi_irq_hub_chk.sv
module spi_irq_hub_chk
  import spi_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic                 ep_cmd_busy,
  input logic [NUM_LINES-1:0] int_state,
  input logic [NUM_LINES-1:0] int_en,
  input logic [ERR_W-1:0]     err_st
);
  logic wr_state, wr_test, wr_errst;
  logic unused_ck;
  assign wr_state  = reg_we && (32'(reg_addr) == AD_STATE);
  assign wr_test   = reg_we && (32'(reg_addr) == AD_TEST);
  assign wr_errst  = reg_we && (32'(reg_addr) == AD_ERR_ST);
  assign unused_ck = ^reg_wdata[DATA_W-1:ERR_W];

  AST_STATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    int_state[0] && !(wr_state && reg_wdata[0]) |=> int_state[0]); // R1
  AST_TEST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_test && reg_wdata[0] && int_en[0] |=> int_state[0]); // R3
  AST_TEST_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_test && reg_wdata[1] && int_en[1] |=> int_state[1]); // R3
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en[1] && !int_state[1] |=> !int_state[1]); // R2
  AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ep_cmd_busy |=> err_st[0]); // R10
  AST_ERRST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_st[3] && !(wr_errst && reg_wdata[3]) |=> err_st[3]); // R7
endmodule

bind spi_irq_hub spi_irq_hub_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ep_cmd_busy(ep_cmd_busy), .int_state(int_state_q),
  .int_en(int_en_q), .err_st(err_st_q)
);

// File: tb/tb_spi_irq_hub.sv
module tb_spi_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        st_ready = 1'b0, st_tx_empty = 1'b0, st_rx_full = 1'b0;
  logic [5:0]  ep = '0;
  logic        irq_err, irq_evt;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  spi_irq_hub dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_ready(st_ready),
    .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
    .ep_cmd_busy(ep[0]), .ep_overflow(ep[1]), .ep_underflow(ep[2]),
    .ep_cmd_inval(ep[3]), .ep_cs_inval(ep[4]), .ep_access_inval(ep[5]),
    .irq_err(irq_err), .irq_evt(irq_evt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk); ep = v;
    @(negedge clk); ep = '0;
    step();
  endtask

  task automatic t_reset();
    check("R6 irq_err", {31'd0, irq_err}, 0);
    check("R6 irq_evt", {31'd0, irq_evt}, 0);
    rd_chk("R6 state", 3'd0, 0);
    rd_chk("R6 enable", 3'd1, 0);
    rd_chk("R12 test reads 0", 3'd2, 0);
    rd_chk("R6 err_en", 3'd4, 32'h1F);
    rd_chk("R6 err_st", 3'd5, 0);
    rd_chk("R6 evt_en", 3'd6, 0);
    rd_chk("R12 unmapped", 3'd7, 0);
  endtask

  task automatic t_test_force();
    wr(3'd1, 32'h3);
    wr(3'd2, 32'h3);
    check("R3 irq_err", {31'd0, irq_err}, 1);
    check("R3 irq_evt", {31'd0, irq_evt}, 1);
    rd_chk("R1 state both", 3'd0, 32'h3);
    rd_chk("R3 test reads 0", 3'd2, 0);
    wr(3'd0, 32'h0);
    rd_chk("R1 write 0 keeps", 3'd0, 32'h3);
    wr(3'd0, 32'h1);
    rd_chk("R1 clear bit0 only", 3'd0, 32'h2);
    check("R1 irq_err cleared", {31'd0, irq_err}, 0);
    wr(3'd0, 32'h2);
    rd_chk("R1 clear bit1", 3'd0, 0);
  endtask

  task automatic t_gate();
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h3);
    rd_chk("R2 test while disabled", 3'd0, 0);
    check("R2 no irq", {30'd0, irq_evt, irq_err}, 0);
    wr(3'd1, 32'h3);
    step();
    rd_chk("R2 enable alone no set", 3'd0, 0);
  endtask

  task automatic t_err_src();
    pulse(6'h01);
    rd_chk("R7 cmd_busy status", 3'd5, 32'h01);
    check("R4 cmd_busy irq", {31'd0, irq_err}, 1);
    repeat (3) step();
    rd_chk("R7 status sticky", 3'd5, 32'h01);
    wr(3'd5, 32'h01);
    rd_chk("R7 status w1c", 3'd5, 0);
    wr(3'd0, 32'h1);
    step();
    check("R4 irq after clears", {31'd0, irq_err}, 0);
    pulse(6'h26);
    rd_chk("R8 ovf/unf/access recorded", 3'd5, 32'h26);
    check("R8 no irq for them", {31'd0, irq_err}, 0);
    wr(3'd5, 32'h3F);
    wr(3'd4, 32'h17);
    pulse(6'h08);
    check("R4 masked cmd_inval", {31'd0, irq_err}, 0);
    rd_chk("R4 cmd_inval status", 3'd5, 32'h08);
    pulse(6'h10);
    check("R4 cs_inval irq", {31'd0, irq_err}, 1);
    wr(3'd5, 32'h18);
    wr(3'd0, 32'h1);
    wr(3'd4, 32'h1F);
    pulse(6'h08);
    check("R4 cmd_inval irq", {31'd0, irq_err}, 1);
    wr(3'd5, 32'h08);
    wr(3'd0, 32'h1);
  endtask

  task automatic evt_one(input string tag, input logic [5:0] en, input logic [2:0] fl);
    wr(3'd6, {26'd0, en});
    @(negedge clk); {st_ready, st_tx_empty, st_rx_full} = fl;
    step();
    check(tag, {31'd0, irq_evt}, 1);
    {st_ready, st_tx_empty, st_rx_full} = '0;
    repeat (2) step();
    check({tag, " R1 sticky"}, {31'd0, irq_evt}, 1);
    wr(3'd0, 32'h2);
    check({tag, " cleared"}, {31'd0, irq_evt}, 0);
  endtask

  task automatic t_evt();
    @(negedge clk); {st_ready, st_tx_empty, st_rx_full} = 3'b111;
    repeat (2) step();
    check("R5 no enable no irq", {31'd0, irq_evt}, 0);
    wr(3'd6, 32'h2C);
    step();
    check("R5 sourceless bits", {31'd0, irq_evt}, 0);
    rd_chk("R5 evt_en stored", 3'd6, 32'h2C);
    {st_ready, st_tx_empty, st_rx_full} = '0;
    evt_one("R5 ready", 6'h10, 3'b100);
    evt_one("R5 tx_empty", 6'h02, 3'b010);
    evt_one("R5 rx_full", 6'h01, 3'b001);
    wr(3'd6, 32'h0);
  endtask

  task automatic t_mask();
    wr(3'd2, 32'h2);
    check("R9 evt set", {31'd0, irq_evt}, 1);
    wr(3'd1, 32'h1);
    check("R9 masked output", {31'd0, irq_evt}, 0);
    rd_chk("R9 state kept", 3'd0, 32'h2);
    wr(3'd1, 32'h3);
    check("R9 unmasked output", {31'd0, irq_evt}, 1);
    wr(3'd0, 32'h2);
  endtask

  task automatic t_race();
    wr(3'd1, 32'h2);
    pulse(6'h08);
    @(negedge clk); reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h09; ep = 6'h01;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0; ep = '0;
    rd_chk("R10 pulse beats clear", 3'd5, 32'h01);
    wr(3'd5, 32'h01);
    rd_chk("R10 later clear", 3'd5, 0);
    wr(3'd1, 32'h3);
  endtask

  task automatic t_alert();
    wr(3'd1, 32'h1);
    wr(3'd4, 32'h0A);
    wr(3'd6, 32'h15);
    wr(3'd3, 32'hFFFF_FFFF);
    step();
    rd_chk("R11 state", 3'd0, 0);
    rd_chk("R11 enable", 3'd1, 32'h1);
    rd_chk("R11 err_en", 3'd4, 32'h0A);
    rd_chk("R11 err_st", 3'd5, 0);
    rd_chk("R11 evt_en", 3'd6, 32'h15);
    rd_chk("R11 alert reads 0", 3'd3, 0);
    check("R11 irqs", {30'd0, irq_evt, irq_err}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_test_force();
    t_gate();
    t_err_src();
    t_evt();
    t_mask();
    t_race();
    t_alert();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule